// File: doc/BRIEF.md
# Serial Configuration and Digit Readback Port

This block is the host-facing serial port of a tone signalling unit. A host drives four pins: an enable strobe, a serial clock, a direction select and a data line. The data line is bidirectional, so it is modelled as a data input, a data output and an output enable. With the direction pin low, the host shifts a 14-bit configuration word in, one bit per serial clock rising edge. It then raises the enable, and the word is committed to the mode-control register and decoded into fields. With the direction pin high, a rising enable takes a snapshot of the current detected digit code. The host then clocks that snapshot out, least significant bit first.

All pins are sampled by the block's own system clock through one register stage. The pins should be held for at least two system clock cycles between changes. Field outputs feed the transmit, receive and power control logic elsewhere in the chip. A sticky flag records any serial clock rise seen while the enable is high.

Top module: `ser_cfg_port`

## Requirements
- R1: With the direction pin low, each serial clock rising edge shifts the data input into a 14-bit shift register, MSB first. The bit order is tone[3:0], gain[3:0], detect[1:0], squelch, mode[2:0], so the last bit shifted is mode bit 0.
- R2: With the direction pin low and the enable high, the shift register is copied into the mode-control register. While the enable is low, the field outputs hold even when new bits are shifted.
- R3: The field outputs come from the committed word at fixed positions: tone = bits 13:10, gain = bits 9:6, detect = bits 5:4, squelch = bit 3, mode = bits 2:0.
- R4: Mode codes 000 to 101 appear unchanged on the mode output. The unused codes 110 and 111 appear as 100, the deepest sleep state.
- R5: With the direction pin high, an enable rising edge captures the 4-bit digit input into the status register. Bit 0 of the capture is presented on the data output before any serial clock edge.
- R6: On a read, the next three serial clock rising edges present capture bits 1, 2 and 3 in that order.
- R7: After bit 3, further serial clock edges cycle through the captured bits again, starting at bit 0. Changes on the digit input have no effect until the next enable rising edge, which captures fresh data.
- R8: The data output enable is low whenever the direction pin is low and high whenever it is high.
- R9: A serial clock rising edge while the enable is high sets the protocol error flag. The flag stays set until reset.
- R10: After reset, the field outputs are all zero (mode 000, receive), the output enable is low, the data output is low and the error flag is clear.
- R11: Serial clock edges during a read leave the shift register untouched. A commit after a read reapplies the last written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| serEn | input | 1 | Enable strobe pin |
| serClk | input | 1 | Serial clock pin |
| serDir | input | 1 | Direction select, 1 = read |
| serDin | input | 1 | Data line input |
| digitIn | input | 4 | Detected digit code from the decoder |
| serDout | output | 1 | Data line output value |
| serDoe | output | 1 | Data line output enable |
| ctlMode | output | 3 | Decoded function mode |
| ctlSquelch | output | 1 | Transmit squelch |
| ctlDetect | output | 2 | Detect and release time select |
| ctlGain | output | 4 | Attenuator or receive gain select |
| ctlTone | output | 4 | Tone select |
| protoErr | output | 1 | Sticky protocol error flag |

## Verification
The bench shifts a second word without raising the enable. A design that commits on every shift would change the fields early. It writes both unused mode codes, which a plain pass-through decoder would leak onto the mode output. On reads it clocks past the fourth bit and changes the digit input mid-read. A design that stops at bit 3 or tracks the live digit would then present the wrong bit. Finally it commits again after a read, to expose read clocks leaking into the shift register, and it raises the serial clock under a high enable to show that the error flag is set and stays set.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int CFG_W  = 14;
  localparam int STAT_W = 4;

  typedef enum logic [2:0] {
    MODE_RX        = 3'b000,
    MODE_TX_DUAL   = 3'b001,
    MODE_TX_SINGLE = 3'b010,
    MODE_SLEEP_LT  = 3'b011,
    MODE_SLEEP_DP  = 3'b100,
    MODE_LOOPBACK  = 3'b101
  } mode_e;

  // Bit order of the committed word; MSB is shifted first.
  typedef struct packed {
    logic [3:0] tone;
    logic [3:0] gain;
    logic [1:0] detect;
    logic       squelch;
    logic [2:0] mode;
  } cfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic readSel;
    logic shiftIn;
    logic commit;
    logic loadStat;
    logic shiftOut;
    logic clkWhileEn;
  } strobe_t;
endpackage

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
  import ser_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    serEn,
  input  logic    serClk,
  input  logic    serDir,
  input  logic    serDin,
  output strobe_t strb,
  output logic    dinS
);
  logic enS, clkS, dirS, enP, clkP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enS  <= 1'b0;
      clkS <= 1'b0;
      dirS <= 1'b0;
      dinS <= 1'b0;
      enP  <= 1'b0;
      clkP <= 1'b0;
    end else begin
      enS  <= serEn;
      clkS <= serClk;
      dirS <= serDir;
      dinS <= serDin;
      enP  <= enS;
      clkP <= clkS;
    end
  end

  logic clkRise, enRise;
  assign clkRise = clkS & ~clkP;
  assign enRise  = enS & ~enP;

  always_comb begin
    strb.readSel    = dirS;
    strb.shiftIn    = ~dirS & clkRise;
    strb.commit     = ~dirS & enS;
    strb.loadStat   = dirS & enRise;
    strb.shiftOut   = dirS & clkRise;
    strb.clkWhileEn = clkRise & enS;
  end
endmodule

// File: rtl/ser_cfg_dpath.sv
module ser_cfg_dpath
  import ser_cfg_pkg::*;
#(
  parameter int CW = CFG_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strb,
  input  logic          dinS,
  input  logic [SW-1:0] digitIn,
  output logic [CW-1:0] cfgWord,
  output logic          serDout,
  output logic          serDoe,
  output logic          protoErr
);
  localparam int IDX_W = (SW > 1) ? $clog2(SW) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SW - 1);

  logic [CW-1:0]    shiftReg;
  logic [SW-1:0]    statusReg;
  logic [IDX_W-1:0] bitIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      cfgWord  <= '0;
    end else begin
      if (strb.shiftIn) shiftReg <= {shiftReg[CW-2:0], dinS};
      if (strb.commit)  cfgWord  <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusReg <= '0;
      bitIdx    <= '0;
    end else if (strb.loadStat) begin
      statusReg <= digitIn;
      bitIdx    <= '0;
    end else if (strb.shiftOut) begin
      bitIdx <= (bitIdx == LAST_IDX) ? '0 : bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serDoe   <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      serDoe <= strb.readSel;
      if (strb.clkWhileEn) protoErr <= 1'b1;
    end
  end

  assign serDout = statusReg[bitIdx];
endmodule

// File: rtl/ser_cfg_decode.sv
module ser_cfg_decode
  import ser_cfg_pkg::*;
(
  input  cfg_t       cfgIn,
  output logic [2:0] modeOut,
  output logic       squelchOut,
  output logic [1:0] detectOut,
  output logic [3:0] gainOut,
  output logic [3:0] toneOut
);
  mode_e modeDec;

  always_comb begin
    case (cfgIn.mode)
      3'b110, 3'b111: modeDec = MODE_SLEEP_DP;
      default:        modeDec = mode_e'(cfgIn.mode);
    endcase
  end

  assign modeOut    = modeDec;
  assign squelchOut = cfgIn.squelch;
  assign detectOut  = cfgIn.detect;
  assign gainOut    = cfgIn.gain;
  assign toneOut    = cfgIn.tone;
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
  import ser_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serEn,
  input  logic              serClk,
  input  logic              serDir,
  input  logic              serDin,
  input  logic [STAT_W-1:0] digitIn,
  output logic              serDout,
  output logic              serDoe,
  output logic [2:0]        ctlMode,
  output logic              ctlSquelch,
  output logic [1:0]        ctlDetect,
  output logic [3:0]        ctlGain,
  output logic [3:0]        ctlTone,
  output logic              protoErr
);
  strobe_t          strb;
  logic             dinS;
  logic [CFG_W-1:0] cfgWord;

  ser_cfg_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .serEn(serEn), .serClk(serClk),
    .serDir(serDir), .serDin(serDin), .strb(strb), .dinS(dinS)
  );

  ser_cfg_dpath #(.CW(CFG_W), .SW(STAT_W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dinS(dinS), .digitIn(digitIn),
    .cfgWord(cfgWord), .serDout(serDout), .serDoe(serDoe), .protoErr(protoErr)
  );

  ser_cfg_decode i_decode (
    .cfgIn(cfg_t'(cfgWord)), .modeOut(ctlMode), .squelchOut(ctlSquelch),
    .detectOut(ctlDetect), .gainOut(ctlGain), .toneOut(ctlTone)
  );
endmodule

// File: rtl/ser_cfg_port_chk.sv
module ser_cfg_port_chk
  import ser_cfg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input strobe_t    strb,
  input logic       serDout,
  input logic       serDoe,
  input logic [2:0] ctlMode,
  input logic       ctlSquelch,
  input logic [1:0] ctlDetect,
  input logic [3:0] ctlGain,
  input logic [3:0] ctlTone,
  input logic       protoErr
);
  logic [13:0] fields;
  assign fields = {ctlTone, ctlGain, ctlDetect, ctlSquelch, ctlMode};

  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlMode != 3'b110) && (ctlMode != 3'b111));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(fields));

  // R8
  doe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.readSel |=> !serDoe);

  // R8
  doe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.readSel |=> serDoe);

  // R9
  perr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clkWhileEn |=> protoErr);

  // R9
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    protoErr |=> protoErr);

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.loadStat && !strb.shiftOut) |=> $stable(serDout));
endmodule

bind ser_cfg_port ser_cfg_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .strb(strb), .serDout(serDout), .serDoe(serDoe),
  .ctlMode(ctlMode), .ctlSquelch(ctlSquelch), .ctlDetect(ctlDetect),
  .ctlGain(ctlGain), .ctlTone(ctlTone), .protoErr(protoErr)
);

// File: tb/test_ser_cfg_port.sv
module test_ser_cfg_port;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serEn = 1'b0, serClk = 1'b0, serDir = 1'b0, serDin = 1'b0;
  logic [3:0] digitIn = 4'h0;
  logic serDout, serDoe, ctlSquelch, protoErr;
  logic [2:0] ctlMode;
  logic [1:0] ctlDetect;
  logic [3:0] ctlGain, ctlTone;

  always #2.5 clk = ~clk;

  ser_cfg_port i_ser_cfg_port (
    .clk(clk), .rst_n(rst_n), .serEn(serEn), .serClk(serClk), .serDir(serDir),
    .serDin(serDin), .digitIn(digitIn), .serDout(serDout), .serDoe(serDoe),
    .ctlMode(ctlMode), .ctlSquelch(ctlSquelch), .ctlDetect(ctlDetect),
    .ctlGain(ctlGain), .ctlTone(ctlTone), .protoErr(protoErr)
  );

  typedef struct {
    int          sel;   // 0 fields, 1 dout, 2 doe, 3 error flag
    logic [13:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic logic [13:0] mkWord(logic [3:0] t, logic [3:0] a,
                                          logic [1:0] cd, logic sq, logic [2:0] m);
    return {t, a, cd, sq, m};
  endfunction

  // R4: unused codes 110 and 111 read back as 100
  function automatic logic [13:0] refFields(logic [13:0] w);
    logic [2:0] m;
    m = (w[2:0] > 3'd5) ? 3'b100 : w[2:0];
    return {w[13:3], m};
  endfunction

  // Monitor: pops expected items and compares them away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [13:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = {ctlTone, ctlGain, ctlDetect, ctlSquelch, ctlMode};
        1:       act = {13'd0, serDout};
        2:       act = {13'd0, serDoe};
        default: act = {13'd0, protoErr};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pushExp(int sel, logic [13:0] e, string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic pulseClk();
    serClk = 1'b1; settle();
    serClk = 1'b0; settle();
  endtask

  task automatic shiftWord(logic [13:0] w, bit doCommit);
    serDir = 1'b0; serEn = 1'b0; settle();
    for (int i = 13; i >= 0; i--) begin
      serDin = w[i]; settle();
      pulseClk();
    end
    if (doCommit) begin
      serEn = 1'b1; settle();
      serEn = 1'b0; settle();
    end
  endtask

  task automatic startRead(logic [3:0] code);
    serEn = 1'b0; serDir = 1'b1; settle();
    digitIn = code; settle();
    serEn = 1'b1; settle();
    serEn = 1'b0; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [13:0] w1, w2, w3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R10 reset state
    pushExp(0, 14'd0, "R10 fields after reset");
    pushExp(2, 14'd0, "R10 doe after reset");
    pushExp(1, 14'd0, "R10 dout after reset");
    pushExp(3, 14'd0, "R10 error flag after reset");

    // R1 R3 basic write and field positions
    w1 = mkWord(4'h9, 4'hC, 2'b10, 1'b1, 3'b001);
    shiftWord(w1, 1'b1);
    pushExp(0, refFields(w1), "R1 R3 written word fields");
    pushExp(2, 14'd0, "R8 doe low during write");

    // R2 shift without commit holds fields, commit applies
    w2 = mkWord(4'h3, 4'h5, 2'b01, 1'b0, 3'b010);
    shiftWord(w2, 1'b0);
    pushExp(0, refFields(w1), "R2 fields hold while enable low");
    serEn = 1'b1; settle(); serEn = 1'b0; settle();
    pushExp(0, refFields(w2), "R2 commit on enable high");

    // R4 mode decode
    shiftWord(mkWord(4'h0, 4'h0, 2'b00, 1'b0, 3'b110), 1'b1);
    pushExp(0, {11'd0, 3'b100}, "R4 code 110 maps to 100");
    shiftWord(mkWord(4'hF, 4'hF, 2'b11, 1'b1, 3'b111), 1'b1);
    pushExp(0, {11'h7FF, 3'b100}, "R4 code 111 maps to 100");
    w3 = mkWord(4'h1, 4'h2, 2'b11, 1'b0, 3'b101);
    shiftWord(w3, 1'b1);
    pushExp(0, refFields(w3), "R4 code 101 passes");

    // R5 R6 R7 readback of 4'b1010
    startRead(4'hA);
    pushExp(2, 14'd1, "R8 doe high during read");
    pushExp(1, 14'd0, "R5 D0 before clocks");
    pulseClk(); pushExp(1, 14'd1, "R6 D1");
    digitIn = 4'h5;
    pulseClk(); pushExp(1, 14'd0, "R6 D2 with digit changed");
    pulseClk(); pushExp(1, 14'd1, "R6 D3");
    pulseClk(); pushExp(1, 14'd0, "R7 repeat D0");
    pulseClk(); pushExp(1, 14'd1, "R7 repeat D1");
    startRead(4'h5);
    pushExp(1, 14'd1, "R7 fresh capture D0");
    pulseClk(); pushExp(1, 14'd0, "R7 fresh capture D1");

    // R11 read clocks did not touch the shift register
    serEn = 1'b0; serDir = 1'b0; settle();
    pushExp(2, 14'd0, "R8 doe low after read");
    serEn = 1'b1; settle(); serEn = 1'b0; settle();
    pushExp(0, refFields(w3), "R11 commit after read keeps word");
    pushExp(3, 14'd0, "R9 flag clear after clean traffic");

    // R9 clock under high enable
    serEn = 1'b1; settle();
    pulseClk();
    serEn = 1'b0; settle();
    pushExp(3, 14'd1, "R9 flag set");
    shiftWord(w1, 1'b1);
    pushExp(3, 14'd1, "R9 flag sticky");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule